// File: doc/BRIEF.md
# Cache Line Disposition Sequencer for Flush and Block IO

This block settles what happens to one cache line when the line is the target of a flush, a block read on behalf of an IO device, or a block write from an IO device. A request carries a reference kind, a word address and the identity (task and subtask) of the issuer. The low address bits select a word inside a 16-word block and are dropped, so the rest names a cache line. The block drives that line number to the cache lookup port in the same cycle. It samples the returned hit and dirty flags when it accepts the request. From that state and the kind it then issues nothing, invalidates the line, starts storage transfers, or runs the ordered flush-store sequence.

Each storage access moves a block as 16 single-word beats that the storage side strobes. The sequencer only routes those strobes. A strobe becomes a device beat, a cache-array beat or both, and it carries the issuer identity and a fault flag. A block read whose line is dirty in the cache still issues a storage read. The data then comes from the cache array, paced by the storage beats, so the device sees the same timing either way. One request is handled at a time, through a ready/valid handshake, and the block stays busy for one extra cycle after each request ends.

Top module: `cline_dispose`

## Requirements
- R1: Kind encoding is 0 flush, 1 block read, 2 block write, 3 no-op. A flush that misses, and any kind-3 request, makes no cache update and no storage request, and `done` pulses in the first cycle after acceptance.
- R2: A flush that hits a clean line makes exactly one cache update with `st_op`=1 (mark vacant) in the first cycle after acceptance, issues no storage request, and pulses `done` in that same cycle.
- R3: A flush that hits a dirty line runs these steps in order. First comes a mark-loading update (`st_op`=0) together with a storage read (`sto_write`=0) in the first cycle after acceptance. The 16 read beats that follow produce no device beat and no cache beat. In the cycle after the last read beat comes a mark-vacant update together with a storage write (`sto_write`=1). During the write, `cache_beat` accompanies each of the 16 beats, and `done` pulses on the last one.
- R4: A block read issues a storage read in the first cycle after acceptance and never updates cache state. It produces one `dev_beat` per storage beat, 16 in all, and `done` on the last. `cache_beat` accompanies every one of those beats when the line hit dirty, and none otherwise.
- R5: A block write issues a storage write in the first cycle after acceptance. On a hit, whether the line is clean or dirty, it marks the line vacant in that same cycle. It produces one `dev_beat` per storage beat, never a `cache_beat`, and `done` on the 16th beat.
- R6: The line number is the address with its low OFF_W (4) bits dropped. `lk_line` follows `req_addr` directly, and `st_line` and `sto_line` carry the accepted line on every update and storage request.
- R7: On every device beat, `dev_id` equals the issuer identity given with the request, and `dev_write` is 1 for a block write and 0 for a block read.
- R8: `dev_fault` is raised exactly on block-read device beats that come from storage while `sto_err` is high. It stays low when the data comes from the cache.
- R9: `req_ready` is high only when the block is idle. It is low from acceptance through the cycle after `done`, and high again in the cycle after that.
- R10: Out of reset, `req_ready` is 1 and `st_we`, `sto_req`, `dev_beat`, `cache_beat` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 2 | 0 flush, 1 block read, 2 block write, 3 no-op |
| req_addr | input | ADDR_W | Word address; low OFF_W bits ignored |
| req_id | input | ID_W | Issuer task and subtask |
| lk_line | output | ADDR_W-OFF_W | Line looked up in the cache tags |
| lk_hit | input | 1 | Line present |
| lk_dirty | input | 1 | Line modified |
| st_we | output | 1 | Cache state update strobe |
| st_op | output | 1 | 0 mark loading, 1 mark vacant |
| st_line | output | ADDR_W-OFF_W | Line being updated |
| sto_req | output | 1 | Storage access request pulse |
| sto_write | output | 1 | 1 write, 0 read |
| sto_line | output | ADDR_W-OFF_W | Line accessed in storage |
| sto_beat | input | 1 | Storage beat strobe |
| sto_err | input | 1 | Uncorrectable error on this read beat |
| dev_beat | output | 1 | Beat to or from the IO device |
| dev_write | output | 1 | Direction of device transfer (1 device to storage) |
| dev_id | output | ID_W | Issuer identity travelling with the data |
| dev_fault | output | 1 | Uncorrectable error on this device read beat |
| cache_beat | output | 1 | Cache array supplies a word this beat |
| done | output | 1 | Request finished |

## Verification
Some rules are checked by assertions on every cycle. A mark-loading update always goes together with a storage read. The mark-vacant step of a flush comes right after a storage beat. Device beats only occur on storage beats. A block read never touches cache state, and a block write never reads the cache array. Faults appear only on storage-sourced device beats. The handshake reopens two cycles after `done`. The bench's sweeps over kind, hit, dirty, storage latency and error position are what show the exact cycle of each step. They also show the beat counts, the line number taken from varying offsets, identity propagation, and the full order of the dirty flush.

// File: rtl/cdisp_pkg.sv
package cdisp_pkg;

   typedef enum logic [1:0] {
      K_FLUSH = 2'd0,
      K_IORD  = 2'd1,
      K_IOWR  = 2'd2,
      K_NONE  = 2'd3
   } ref_kind_e;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_DISP = 3'd1,
      S_RD   = 3'd2,
      S_VAC  = 3'd3,
      S_WR   = 3'd4,
      S_COOL = 3'd5
   } seq_state_e;

   typedef struct packed {
      logic mark_loading;
      logic mark_vacant;
      logic issue_rd;
      logic issue_wr;
      logic finish;
      logic from_cache;
   } disp_plan_t;

endpackage

// File: rtl/cdisp_plan.sv
module cdisp_plan
   import cdisp_pkg::*;
(
   input  ref_kind_e  kind,
   input  logic       hit,
   input  logic       dirty,
   output disp_plan_t plan
);

   logic hit_dirty;
   assign hit_dirty = hit & dirty;

   always_comb begin
      plan = '0;
      unique case (kind)
         K_FLUSH: begin
            if (hit_dirty) begin
               plan.mark_loading = 1'b1;
               plan.issue_rd     = 1'b1;
            end else begin
               plan.mark_vacant = hit;
               plan.finish      = 1'b1;
            end
         end
         K_IORD: begin
            plan.issue_rd   = 1'b1;
            plan.from_cache = hit_dirty;
         end
         K_IOWR: begin
            plan.mark_vacant = hit;
            plan.issue_wr    = 1'b1;
         end
         default: begin
            plan.finish = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/cdisp_beats.sv
module cdisp_beats #(
   parameter int BEATS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic beat,
   output logic last
);

   generate
      if (BEATS < 1) begin : g_bad_beats
         $error("cdisp_beats: BEATS must be at least 1");
      end

      if (BEATS == 1) begin : g_single
         assign last = en & beat;
      end else begin : g_count
         localparam int CW = $clog2(BEATS);
         localparam logic [CW-1:0] TOP = CW'(BEATS - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (en && beat) begin
               cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
            end
         end

         assign last = en & beat & (cnt_q == TOP);

         a_r3_cnt_in_range : assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= TOP);
         a_r4_cnt_wraps_on_last : assert property (@(posedge clk) disable iff (!rst_n)
            last |=> (cnt_q == '0));
      end
   endgenerate

endmodule

// File: rtl/cline_dispose.sv
module cline_dispose
   import cdisp_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 4,
   parameter int ID_W   = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [1:0]              req_kind,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [ID_W-1:0]         req_id,
   output logic [ADDR_W-OFF_W-1:0] lk_line,
   input  logic                    lk_hit,
   input  logic                    lk_dirty,
   output logic                    st_we,
   output logic                    st_op,
   output logic [ADDR_W-OFF_W-1:0] st_line,
   output logic                    sto_req,
   output logic                    sto_write,
   output logic [ADDR_W-OFF_W-1:0] sto_line,
   input  logic                    sto_beat,
   input  logic                    sto_err,
   output logic                    dev_beat,
   output logic                    dev_write,
   output logic [ID_W-1:0]         dev_id,
   output logic                    dev_fault,
   output logic                    cache_beat,
   output logic                    done
);

   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int BEATS  = 1 << OFF_W;

   generate
      if (OFF_W < 1 || OFF_W > 8) begin : g_bad_off
         $error("cline_dispose: OFF_W out of range");
      end
      if (LINE_W < 1) begin : g_bad_addr
         $error("cline_dispose: ADDR_W must exceed OFF_W");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("cline_dispose: ID_W must be positive");
      end
   endgenerate

   seq_state_e        state_q, state_d;
   ref_kind_e         kind_q;
   logic [LINE_W-1:0] line_q;
   logic [ID_W-1:0]   id_q;
   logic              hit_q, dirty_q;
   disp_plan_t        plan;
   logic              accept, window, last_beat, src_cache;

   assign req_ready = (state_q == S_IDLE);
   assign accept    = req_valid & req_ready;
   assign lk_line   = req_addr[ADDR_W-1:OFF_W];

   cdisp_plan u_plan (
      .kind  (kind_q),
      .hit   (hit_q),
      .dirty (dirty_q),
      .plan  (plan)
   );

   assign window = (state_q == S_RD) | (state_q == S_WR);

   cdisp_beats #(.BEATS(BEATS)) u_beats (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (window),
      .beat  (sto_beat),
      .last  (last_beat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         kind_q  <= K_NONE;
         line_q  <= '0;
         id_q    <= '0;
         hit_q   <= 1'b0;
         dirty_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            kind_q  <= ref_kind_e'(req_kind);
            line_q  <= req_addr[ADDR_W-1:OFF_W];
            id_q    <= req_id;
            hit_q   <= lk_hit;
            dirty_q <= lk_dirty;
         end
      end
   end

   always_comb begin
      state_d   = state_q;
      st_we     = 1'b0;
      st_op     = 1'b0;
      sto_req   = 1'b0;
      sto_write = 1'b0;
      done      = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (accept) state_d = S_DISP;
         end
         S_DISP: begin
            st_we     = plan.mark_loading | plan.mark_vacant;
            st_op     = plan.mark_vacant;
            sto_req   = plan.issue_rd | plan.issue_wr;
            sto_write = plan.issue_wr;
            if (plan.finish) begin
               done    = 1'b1;
               state_d = S_COOL;
            end else if (plan.issue_rd) begin
               state_d = S_RD;
            end else begin
               state_d = S_WR;
            end
         end
         S_RD: begin
            if (last_beat) begin
               if (kind_q == K_FLUSH) begin
                  state_d = S_VAC;
               end else begin
                  done    = 1'b1;
                  state_d = S_COOL;
               end
            end
         end
         S_VAC: begin
            st_we     = 1'b1;
            st_op     = 1'b1;
            sto_req   = 1'b1;
            sto_write = 1'b1;
            state_d   = S_WR;
         end
         S_WR: begin
            if (last_beat) begin
               done    = 1'b1;
               state_d = S_COOL;
            end
         end
         default: begin
            state_d = S_IDLE;
         end
      endcase
   end

   assign st_line  = line_q;
   assign sto_line = line_q;
   assign dev_id   = id_q;

   assign src_cache  = hit_q & dirty_q;
   assign dev_write  = (kind_q == K_IOWR);
   assign dev_beat   = sto_beat & (((state_q == S_RD) & (kind_q == K_IORD)) |
                                   ((state_q == S_WR) & (kind_q == K_IOWR)));
   assign cache_beat = sto_beat & (((state_q == S_RD) & (kind_q == K_IORD) & src_cache) |
                                   ((state_q == S_WR) & (kind_q == K_FLUSH)));
   assign dev_fault  = sto_beat & sto_err & (state_q == S_RD) &
                       (kind_q == K_IORD) & ~src_cache;

   // R3: loading mark is only ever paired with the dummy storage read
   a_r3_loading_with_read : assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && !st_op) |-> (sto_req && !sto_write));

   // R3: the flush vacate-and-writeback step directly follows a read beat
   a_r3_vacate_after_beat : assert property (@(posedge clk) disable iff (!rst_n)
      (st_we && st_op && sto_write && kind_q == K_FLUSH) |-> $past(sto_beat));

   a_r4_dev_on_storage_beat : assert property (@(posedge clk) disable iff (!rst_n)
      dev_beat |-> sto_beat);

   a_r4_read_no_state_change : assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == K_IORD && !req_ready) |-> !st_we);

   a_r5_write_no_cache_read : assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == K_IOWR && !req_ready) |-> !cache_beat);

   a_r8_fault_only_storage_data : assert property (@(posedge clk) disable iff (!rst_n)
      dev_fault |-> (dev_beat && !cache_beat && !dev_write));

   a_r9_busy_after_done : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !req_ready);

   a_r9_ready_returns : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ##2 req_ready);

   a_r1_update_isolated : assert property (@(posedge clk) disable iff (!rst_n)
      st_we |=> !st_we);

endmodule

// File: tb/cline_dispose_bench.sv
module cline_dispose_bench;

   localparam int ADDR_W = 16;
   localparam int OFF_W  = 4;
   localparam int ID_W   = 6;
   localparam int LW     = ADDR_W - OFF_W;
   localparam int NB     = 1 << OFF_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [1:0] req_kind = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [ID_W-1:0] req_id = '0;
   logic [LW-1:0] lk_line;
   logic lk_hit = 1'b0, lk_dirty = 1'b0;
   logic st_we, st_op;
   logic [LW-1:0] st_line;
   logic sto_req, sto_write;
   logic [LW-1:0] sto_line;
   logic sto_beat = 1'b0, sto_err = 1'b0;
   logic dev_beat, dev_write, dev_fault, cache_beat, done;
   logic [ID_W-1:0] dev_id;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   cline_dispose #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ID_W(ID_W)) u_cline_dispose (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_addr(req_addr), .req_id(req_id),
      .lk_line(lk_line), .lk_hit(lk_hit), .lk_dirty(lk_dirty),
      .st_we(st_we), .st_op(st_op), .st_line(st_line),
      .sto_req(sto_req), .sto_write(sto_write), .sto_line(sto_line),
      .sto_beat(sto_beat), .sto_err(sto_err),
      .dev_beat(dev_beat), .dev_write(dev_write), .dev_id(dev_id),
      .dev_fault(dev_fault), .cache_beat(cache_beat), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_ref(input int kind, input int addr, input int id,
                          input bit hit, input bit dirty, input int gap, input int errb);
      int nload, nvac, cload, cvac, nrd, nwr, crd, cwr, ndev, ncache, nfault;
      int idbad, dirbad, linebad, cdone, rdy_busy_bad;
      int s_wait, s_left, s_no;
      bit s_act, s_isrd, hd;
      int exp_line;
      nload = 0; nvac = 0; cload = -1; cvac = -1; nrd = 0; nwr = 0; crd = -1; cwr = -1;
      ndev = 0; ncache = 0; nfault = 0; idbad = 0; dirbad = 0; linebad = 0;
      cdone = -1; rdy_busy_bad = 0;
      s_act = 0; s_wait = 0; s_left = 0; s_no = 0; s_isrd = 0;
      hd = hit && dirty;
      exp_line = addr >> OFF_W;

      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = 2'(kind);
      req_addr  = ADDR_W'(addr);
      req_id    = ID_W'(id);
      lk_hit    = hit;
      lk_dirty  = dirty;
      #1;
      chk(req_ready == 1'b1, "R9 ready when idle", int'(req_ready), 1);
      chk(int'(lk_line) == exp_line, "R6 lookup line", int'(lk_line), exp_line);
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = ADDR_W'(addr ^ 16'hffff);
      for (int c = 1; c < 200; c++) begin
         sto_beat = 1'b0;
         sto_err  = 1'b0;
         if (s_act) begin
            if (s_wait > 0) begin
               s_wait--;
            end else begin
               sto_beat = 1'b1;
               sto_err  = s_isrd && (s_no == errb);
               s_no++;
               s_left--;
               if (s_left == 0) s_act = 0;
            end
         end
         #1;
         if (cdone < 0 && req_ready) rdy_busy_bad++;
         if (st_we) begin
            if (int'(st_line) != exp_line) linebad++;
            if (st_op) begin nvac++; cvac = c; end
            else begin nload++; cload = c; end
         end
         if (sto_req) begin
            if (int'(sto_line) != exp_line) linebad++;
            if (sto_write) begin nwr++; cwr = c; end
            else begin nrd++; crd = c; end
            s_act = 1; s_wait = gap; s_left = NB; s_no = 0; s_isrd = !sto_write;
         end
         if (dev_beat) begin
            ndev++;
            if (int'(dev_id) != id) idbad++;
            if (dev_write != (kind == 2)) dirbad++;
         end
         if (cache_beat) ncache++;
         if (dev_fault) nfault++;
         if (done && cdone < 0) begin
            cdone = c;
         end else if (cdone >= 0 && c == cdone + 1) begin
            chk(req_ready == 1'b0, "R9 busy one cycle after done", int'(req_ready), 0);
         end else if (cdone >= 0 && c == cdone + 2) begin
            chk(req_ready == 1'b1, "R9 ready again", int'(req_ready), 1);
            break;
         end
         @(negedge clk);
      end
      sto_beat = 1'b0;
      sto_err  = 1'b0;
      chk(rdy_busy_bad == 0, "R9 not ready while busy", rdy_busy_bad, 0);
      chk(linebad == 0, "R6 update/storage line", linebad, 0);
      chk(idbad == 0, "R7 device identity", idbad, 0);
      chk(dirbad == 0, "R7 device direction", dirbad, 0);

      if (kind == 3 || (kind == 0 && !hit)) begin
         chk(cdone == 1, "R1 done after accept", cdone, 1);
         chk(nload + nvac + nrd + nwr == 0, "R1 no activity", nload + nvac + nrd + nwr, 0);
      end else if (kind == 0 && !dirty) begin
         chk(cdone == 1, "R2 done at once", cdone, 1);
         chk(nvac == 1 && cvac == 1 && nload == 0, "R2 vacate cycle", cvac, 1);
         chk(nrd + nwr == 0, "R2 no storage", nrd + nwr, 0);
      end else if (kind == 0) begin
         chk(nload == 1 && cload == 1, "R3 loading mark cycle", cload, 1);
         chk(nrd == 1 && crd == 1, "R3 dummy read cycle", crd, 1);
         chk(nvac == 1 && cvac == 18 + gap, "R3 vacate cycle", cvac, 18 + gap);
         chk(nwr == 1 && cwr == 18 + gap, "R3 writeback cycle", cwr, 18 + gap);
         chk(ncache == NB, "R3 victim cache beats", ncache, NB);
         chk(ndev == 0 && nfault == 0, "R3 no device beats", ndev, 0);
         chk(cdone == 34 + 2 * gap, "R3 done cycle", cdone, 34 + 2 * gap);
      end else if (kind == 1) begin
         chk(nrd == 1 && crd == 1 && nwr == 0, "R4 storage read issued", crd, 1);
         chk(nload + nvac == 0, "R4 no cache update", nload + nvac, 0);
         chk(ndev == NB, "R4 device beats", ndev, NB);
         chk(ncache == (hd ? NB : 0), "R4 cache source", ncache, hd ? NB : 0);
         chk(nfault == ((!hd && errb < NB) ? 1 : 0), "R8 fault count", nfault,
             (!hd && errb < NB) ? 1 : 0);
         chk(cdone == 17 + gap, "R4 done cycle", cdone, 17 + gap);
      end else begin
         chk(nwr == 1 && cwr == 1 && nrd == 0, "R5 storage write issued", cwr, 1);
         chk(nvac == (hit ? 1 : 0) && nload == 0, "R5 hit invalidation", nvac, hit ? 1 : 0);
         if (hit) chk(cvac == 1, "R5 invalidate cycle", cvac, 1);
         chk(ncache == 0, "R5 no writeback", ncache, 0);
         chk(ndev == NB && nfault == 0, "R5 device beats", ndev, NB);
         chk(cdone == 17 + gap, "R5 done cycle", cdone, 17 + gap);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(req_ready == 1'b1, "R10 reset ready", int'(req_ready), 1);
      chk(st_we == 1'b0 && sto_req == 1'b0, "R10 reset idle strobes", int'(st_we) + int'(sto_req), 0);
      chk(dev_beat == 1'b0 && cache_beat == 1'b0 && done == 1'b0, "R10 reset beats",
          int'(dev_beat) + int'(cache_beat) + int'(done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         for (int hm = 0; hm < 4; hm++) begin
            for (int g = 0; g < 2; g++) begin
               int n;
               n = k * 8 + hm * 2 + g;
               run_ref(k, (n * 4099 + n * 17) & 16'hffff, (n * 7 + 3) % 64,
                       hm[1], hm[0], g * 2, (n * 5) % 17);
            end
         end
      end
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int w = 0; w < 100000; w++) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule